// File: doc/BRIEF.md
# Punched-Tape Reader Programmed-I/O Controller

This block connects an eight-channel punched-tape reader to the programmed-I/O bus of a small computer. The host places a six-bit device code on its select lines and raises one of three I/O pulse lines. When the code addresses this device, each pulse line has its own job. The first pulse tests the reader flag through the skip line. The second gates the buffered character onto eight bus-in lines. The third empties the buffer, drops the flag and starts the reader running.

The reader side presents eight active-low hole-sense lines and a reader clock. A complete high-then-low pulse on the reader clock loads the inverted hole levels into the character buffer. The same pulse sets the reader flag and the enable state. The flag drives the interrupt-request line. Two small state bits follow the feed-hole and shift inputs and are brought out in true and complement form. Every register runs on one system clock. The active-low initialize input resets all state.

Top module: `ptr_io_ctrl`

## Requirements
- R1: The device is selected only when `dev_sel` equals 6'b111111. While selected, `sel_p1` follows `pulse_p1` and `sel_p2` follows `pulse_p2` in the same cycle, and `sel_p4_n` is the inverse of `pulse_p4`. For any other code, `sel_p1` and `sel_p2` are 0 and `sel_p4_n` is 1.
- R2: A falling edge on `rdr_clk` sets every bit i of the buffer to the inverse of `hole_n[i]` at the next system clock edge. The falling edge is seen as high in one clock sample and low in the next.
- R3: `bus_in` carries the buffer, with bit i taken from hole line i, only while `sel_p2` is active. At all other times `bus_in` is zero.
- R4: `io_int` equals the reader flag. `io_skip` is 1 exactly when `sel_p1` is active and the flag is set.
- R5: A rising edge of the selected `pulse_p4` empties the buffer and clears the flag at the next clock edge. Holding the pulse high does not clear again. A capture in the same cycle takes priority and leaves the new character with the flag set.
- R6: A rising edge of the selected `pulse_p4` sets `rdr_run` and `pwr_on`.
- R7: `stop_done` high clears `rdr_run` at the next clock edge, unless a start happens in the same cycle. It leaves `pwr_on` unchanged.
- R8: A reader-clock capture sets the enable state, which drives `enable_n` low.
- R9: While `init_n` is low, each clock edge clears run, power, enable, buffer, flag and both state bits. The outputs then show `rdr_run`=0, `pwr_on`=0, `enable_n`=1, `io_int`=0, `st_a`=`st_b`=0 and `st_a_n`=`st_b_n`=1.
- R10: A rising edge of `feed_hole` loads state A with (`rdr_run` OR `feed_sw`). A rising edge of `shift_in` loads state B with A. Each bit appears on its true output and on its complement output.
- R11: A `pulse_p4` edge that arrives with a code other than all ones has no effect on the buffer or the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| init_n | input | 1 | Active-low initialize, synchronous |
| dev_sel | input | 6 | Device code from the host |
| pulse_p1 | input | 1 | I/O pulse for the flag test |
| pulse_p2 | input | 1 | I/O pulse for the data read |
| pulse_p4 | input | 1 | I/O pulse for clear and start |
| rdr_clk | input | 1 | Reader strobe; capture on its falling edge |
| hole_n | input | 8 | Active-low hole-sense lines |
| feed_hole | input | 1 | Feed-hole sense |
| feed_sw | input | 1 | Manual feed switch |
| stop_done | input | 1 | Reader stop finished |
| shift_in | input | 1 | Shift strobe for state B |
| sel_p1 | output | 1 | Decoded flag-test pulse |
| sel_p2 | output | 1 | Decoded read pulse |
| sel_p4_n | output | 1 | Decoded clear/start pulse, active low |
| bus_in | output | 8 | Character to the host bus |
| io_skip | output | 1 | Skip request |
| io_int | output | 1 | Interrupt request (reader flag) |
| rdr_run | output | 1 | Reader run state |
| pwr_on | output | 1 | Reader power state |
| enable_n | output | 1 | Enable state, complement form |
| st_a | output | 1 | State A |
| st_a_n | output | 1 | State A complement |
| st_b | output | 1 | State B |
| st_b_n | output | 1 | State B complement |

## Verification
A corrupted buffer shows up on `bus_in` in the same cycle that `sel_p2` is next raised. A wrong flag shows up at once on `io_int`, and on `io_skip` at the next flag test. A faulty edge detector shows its effect one clock after the stimulus. A repeat clear under a held pulse wipes a fresh capture. A missed clear leaves the flag high, and a falling edge that is not recognised leaves the old character in place. Run, power, enable and the two state bits are registered straight to pins, so any fault in them is visible one clock after the causing edge.

// File: rtl/ptr_pkg.sv
package ptr_pkg;

    typedef struct packed {
        logic run;
        logic pwr;
        logic en;
        logic st_a;
        logic st_b;
    } ctrl_st_t;

    localparam ctrl_st_t CTRL_RST = '{run: 1'b0, pwr: 1'b0, en: 1'b0, st_a: 1'b0, st_b: 1'b0};

endpackage

// File: rtl/ptr_edge.sv
module ptr_edge #(
    parameter int          N       = 4,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         init_n,
    input  logic [N-1:0] level,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_d, prev_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign rise[i]   = level[i] & ~prev_q[i];
        assign prev_d[i] = level[i];
    end

    always_ff @(posedge clk) begin
        if (!init_n) prev_q <= RST_VAL;
        else         prev_q <= prev_d;
    end
endmodule

// File: rtl/ptr_decode.sv
module ptr_decode #(
    parameter int               SEL_W    = 6,
    parameter logic [SEL_W-1:0] DEV_CODE = '1
) (
    input  logic [SEL_W-1:0] dev_sel,
    input  logic             pulse_p1,
    input  logic             pulse_p2,
    input  logic             pulse_p4,
    output logic             dec_p1,
    output logic             dec_p2,
    output logic             dec_p4
);
    logic hit;

    always_comb begin
        hit    = (dev_sel == DEV_CODE);
        dec_p1 = hit & pulse_p1;
        dec_p2 = hit & pulse_p2;
        dec_p4 = hit & pulse_p4;
    end
endmodule

// File: rtl/ptr_buffer.sv
module ptr_buffer #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              init_n,
    input  logic              cap,
    input  logic              clr,
    input  logic [DATA_W-1:0] hole_n,
    input  logic              gate,
    output logic [DATA_W-1:0] bus_out,
    output logic              flag
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              flag;
    } buf_st_t;

    buf_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.data = '0;
            st_d.flag = 1'b0;
        end
        if (cap) begin
            st_d.data = ~hole_n;
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!init_n) st_q <= '0;
        else         st_q <= st_d;
    end

    assign bus_out = gate ? st_q.data : '0;
    assign flag    = st_q.flag;

    AST_CAPTURE_SETS_FLAG: assert property (@(posedge clk) disable iff (!init_n)
        cap |=> flag); // R2
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!init_n)
        (clr && !cap) |=> (!flag && st_q.data == '0)); // R5
endmodule

// File: rtl/ptr_ctrl.sv
module ptr_ctrl
    import ptr_pkg::*;
(
    input  logic     clk,
    input  logic     init_n,
    input  logic     start,
    input  logic     stop,
    input  logic     cap,
    input  logic     feed_rise,
    input  logic     shift_rise,
    input  logic     feed_sw,
    output ctrl_st_t st
);
    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.run = 1'b1;
            st_d.pwr = 1'b1;
        end else if (stop) begin
            st_d.run = 1'b0;
        end
        if (cap)        st_d.en   = 1'b1;
        if (feed_rise)  st_d.st_a = st_q.run | feed_sw;
        if (shift_rise) st_d.st_b = st_q.st_a;
    end

    always_ff @(posedge clk) begin
        if (!init_n) st_q <= CTRL_RST;
        else         st_q <= st_d;
    end

    assign st = st_q;

    AST_INIT_CLEARS: assert property (@(posedge clk)
        !init_n |=> (!st_q.run && !st_q.pwr && !st_q.en)); // R9
    AST_STOP_DROPS_RUN: assert property (@(posedge clk) disable iff (!init_n)
        (stop && !start) |=> !st_q.run); // R7
    AST_ENABLE_ON_CAPTURE: assert property (@(posedge clk) disable iff (!init_n)
        cap |=> st_q.en); // R8
    AST_START_POWERS: assert property (@(posedge clk) disable iff (!init_n)
        start |=> (st_q.run && st_q.pwr)); // R6
endmodule

// File: rtl/ptr_io_ctrl.sv
module ptr_io_ctrl
    import ptr_pkg::*;
#(
    parameter int               DATA_W   = 8,
    parameter int               SEL_W    = 6,
    parameter logic [SEL_W-1:0] DEV_CODE = '1
) (
    input  logic              clk,
    input  logic              init_n,
    input  logic [SEL_W-1:0]  dev_sel,
    input  logic              pulse_p1,
    input  logic              pulse_p2,
    input  logic              pulse_p4,
    input  logic              rdr_clk,
    input  logic [DATA_W-1:0] hole_n,
    input  logic              feed_hole,
    input  logic              feed_sw,
    input  logic              stop_done,
    input  logic              shift_in,
    output logic              sel_p1,
    output logic              sel_p2,
    output logic              sel_p4_n,
    output logic [DATA_W-1:0] bus_in,
    output logic              io_skip,
    output logic              io_int,
    output logic              rdr_run,
    output logic              pwr_on,
    output logic              enable_n,
    output logic              st_a,
    output logic              st_a_n,
    output logic              st_b,
    output logic              st_b_n
);
    localparam int EV_N = 4;

    logic            dec_p1, dec_p2, dec_p4;
    logic [EV_N-1:0] ev_lvl, ev_rise;
    logic            flag;
    ctrl_st_t        cst;

    ptr_decode #(.SEL_W(SEL_W), .DEV_CODE(DEV_CODE)) u_dec (
        .dev_sel (dev_sel),
        .pulse_p1(pulse_p1),
        .pulse_p2(pulse_p2),
        .pulse_p4(pulse_p4),
        .dec_p1  (dec_p1),
        .dec_p2  (dec_p2),
        .dec_p4  (dec_p4)
    );

    // bit 0 watches the inverted reader clock, so its rise marks the falling edge
    assign ev_lvl = {shift_in, feed_hole, dec_p4, ~rdr_clk};

    ptr_edge #(.N(EV_N), .RST_VAL(4'b0001)) u_edge (
        .clk   (clk),
        .init_n(init_n),
        .level (ev_lvl),
        .rise  (ev_rise)
    );

    ptr_buffer #(.DATA_W(DATA_W)) u_buf (
        .clk    (clk),
        .init_n (init_n),
        .cap    (ev_rise[0]),
        .clr    (ev_rise[1]),
        .hole_n (hole_n),
        .gate   (dec_p2),
        .bus_out(bus_in),
        .flag   (flag)
    );

    ptr_ctrl u_ctrl (
        .clk       (clk),
        .init_n    (init_n),
        .start     (ev_rise[1]),
        .stop      (stop_done),
        .cap       (ev_rise[0]),
        .feed_rise (ev_rise[2]),
        .shift_rise(ev_rise[3]),
        .feed_sw   (feed_sw),
        .st        (cst)
    );

    assign sel_p1   = dec_p1;
    assign sel_p2   = dec_p2;
    assign sel_p4_n = ~dec_p4;
    assign io_int   = flag;
    assign io_skip  = dec_p1 & flag;
    assign rdr_run  = cst.run;
    assign pwr_on   = cst.pwr;
    assign enable_n = ~cst.en;
    assign st_a     = cst.st_a;
    assign st_a_n   = ~cst.st_a;
    assign st_b     = cst.st_b;
    assign st_b_n   = ~cst.st_b;

    AST_BUS_IDLE_ZERO: assert property (@(posedge clk) disable iff (!init_n)
        !sel_p2 |-> (bus_in == '0)); // R3
    AST_SKIP_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!init_n)
        io_skip |-> io_int); // R4
    AST_DECODE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!init_n)
        (dev_sel != DEV_CODE) |-> (!sel_p1 && !sel_p2 && sel_p4_n)); // R1
endmodule

// File: tb/ptr_io_ctrl_test.sv
module ptr_io_ctrl_test;
    logic       clk = 1'b0;
    logic       init_n;
    logic [5:0] dev_sel;
    logic       pulse_p1, pulse_p2, pulse_p4;
    logic       rdr_clk;
    logic [7:0] hole_n;
    logic       feed_hole, feed_sw, stop_done, shift_in;
    logic       sel_p1, sel_p2, sel_p4_n;
    logic [7:0] bus_in;
    logic       io_skip, io_int, rdr_run, pwr_on, enable_n;
    logic       st_a, st_a_n, st_b, st_b_n;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    ptr_io_ctrl uut (
        .clk(clk), .init_n(init_n), .dev_sel(dev_sel),
        .pulse_p1(pulse_p1), .pulse_p2(pulse_p2), .pulse_p4(pulse_p4),
        .rdr_clk(rdr_clk), .hole_n(hole_n), .feed_hole(feed_hole),
        .feed_sw(feed_sw), .stop_done(stop_done), .shift_in(shift_in),
        .sel_p1(sel_p1), .sel_p2(sel_p2), .sel_p4_n(sel_p4_n),
        .bus_in(bus_in), .io_skip(io_skip), .io_int(io_int),
        .rdr_run(rdr_run), .pwr_on(pwr_on), .enable_n(enable_n),
        .st_a(st_a), .st_a_n(st_a_n), .st_b(st_b), .st_b_n(st_b_n)
    );

    // {dev_sel, p1, p2, p4, exp sel_p1, exp sel_p2, exp sel_p4_n}
    localparam int NV = 10;
    localparam logic [11:0] VEC [NV] = '{
        {6'h3F, 3'b000, 3'b001},
        {6'h3F, 3'b100, 3'b101},
        {6'h3F, 3'b010, 3'b011},
        {6'h3F, 3'b001, 3'b000},
        {6'h3E, 3'b111, 3'b001},
        {6'h1F, 3'b111, 3'b001},
        {6'h00, 3'b111, 3'b001},
        {6'h3F, 3'b111, 3'b110},
        {6'h3D, 3'b100, 3'b001},
        {6'h3F, 3'b110, 3'b111}
    };

    task automatic chk(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic capture(input logic [7:0] h);
        hole_n  = h;
        rdr_clk = 1'b1;
        step();
        rdr_clk = 1'b0;
        step();
    endtask

    task automatic read_bus(input string req, input logic [7:0] exp);
        dev_sel  = 6'h3F;
        pulse_p2 = 1'b1;
        #1;
        chk(bus_in == exp, req, bus_in, exp);
        pulse_p2 = 1'b0;
        #1;
    endtask

    initial begin
        #(4 * 100000);
        total++;
        bad++;
        $display("FAIL watchdog actual=%h expected=%h", 8'h01, 8'h00);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        init_n = 1'b0; dev_sel = '0; pulse_p1 = 0; pulse_p2 = 0; pulse_p4 = 0;
        rdr_clk = 0; hole_n = '1; feed_hole = 0; feed_sw = 0; stop_done = 0; shift_in = 0;
        @(negedge clk);
        step(); step();

        // R9: reset state
        chk(!rdr_run && !pwr_on && enable_n, "R9 reset ctrl", {5'b0, rdr_run, pwr_on, enable_n}, 8'h01);
        chk(!io_int && st_a_n && st_b_n && !st_a && !st_b, "R9 reset flag/state",
            {3'b0, io_int, st_a, st_a_n, st_b, st_b_n}, 8'h05);
        init_n = 1'b1;
        step();

        // R1: decode table
        for (int i = 0; i < NV; i++) begin
            dev_sel  = VEC[i][11:6];
            pulse_p1 = VEC[i][5];
            pulse_p2 = VEC[i][4];
            pulse_p4 = VEC[i][3];
            #1;
            chk({sel_p1, sel_p2, sel_p4_n} == VEC[i][2:0], "R1 decode",
                {5'b0, sel_p1, sel_p2, sel_p4_n}, {5'b0, VEC[i][2:0]});
            pulse_p1 = 0; pulse_p2 = 0; pulse_p4 = 0;
            step();
        end

        // R2, R8, R3: capture and read
        capture(8'hA6);
        chk(io_int, "R2 flag after capture", {7'b0, io_int}, 8'h01);
        chk(!enable_n, "R8 enable after capture", {7'b0, enable_n}, 8'h00);
        read_bus("R2 inverted data", 8'h59);
        chk(bus_in == 8'h00, "R3 bus idle zero", bus_in, 8'h00);

        // R4: skip with flag set
        pulse_p1 = 1'b1;
        #1;
        chk(io_skip, "R4 skip flag set", {7'b0, io_skip}, 8'h01);
        pulse_p1 = 1'b0;
        step();

        // R11: wrong code clear ignored
        dev_sel = 6'h3E; pulse_p4 = 1'b1;
        step();
        pulse_p4 = 1'b0; dev_sel = 6'h3F;
        step();
        chk(io_int, "R11 flag kept", {7'b0, io_int}, 8'h01);
        read_bus("R11 data kept", 8'h59);

        // R5, R6: clear and start
        pulse_p4 = 1'b1;
        step();
        chk(!io_int, "R5 flag cleared", {7'b0, io_int}, 8'h00);
        read_bus("R5 buffer cleared", 8'h00);
        pulse_p1 = 1'b1;
        #1;
        chk(!io_skip, "R4 no skip when flag clear", {7'b0, io_skip}, 8'h00);
        pulse_p1 = 1'b0;
        chk(rdr_run && pwr_on, "R6 run and power set", {6'b0, rdr_run, pwr_on}, 8'h03);
        capture(8'h00);
        step();
        chk(io_int, "R5 held pulse no reclear", {7'b0, io_int}, 8'h01);
        read_bus("R5 capture under held pulse", 8'hFF);
        pulse_p4 = 1'b0;
        step();

        // R7: stop clears run only
        stop_done = 1'b1;
        step();
        stop_done = 1'b0;
        chk(!rdr_run && pwr_on, "R7 stop", {6'b0, rdr_run, pwr_on}, 8'h01);

        // R10: state bits
        feed_hole = 1'b1;
        step();
        chk(!st_a && st_a_n, "R10 A from idle", {6'b0, st_a, st_a_n}, 8'h01);
        feed_hole = 1'b0;
        step();
        feed_sw = 1'b1; feed_hole = 1'b1;
        step();
        chk(st_a && !st_a_n, "R10 A from feed switch", {6'b0, st_a, st_a_n}, 8'h02);
        shift_in = 1'b1;
        step();
        chk(st_b && !st_b_n, "R10 B shifted", {6'b0, st_b, st_b_n}, 8'h02);
        feed_hole = 0; feed_sw = 0; shift_in = 0;
        step();

        // R9: initialize again
        init_n = 1'b0;
        step();
        chk(!rdr_run && !pwr_on && enable_n && !io_int, "R9 init clears",
            {4'b0, rdr_run, pwr_on, enable_n, io_int}, 8'h02);
        chk(!st_a && !st_b, "R9 init clears state", {6'b0, st_a, st_b}, 8'h00);
        init_n = 1'b1;
        step();

        // R5: capture wins over clear in same cycle
        hole_n  = 8'h3C;
        rdr_clk = 1'b1;
        step();
        rdr_clk = 1'b0; dev_sel = 6'h3F; pulse_p4 = 1'b1;
        step();
        pulse_p4 = 1'b0;
        chk(io_int, "R5 capture priority flag", {7'b0, io_int}, 8'h01);
        read_bus("R5 capture priority data", 8'hC3);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule